// File: doc/BRIEF.md
# Direction Reversal Guard

This block stands between an asynchronous forward/reverse request and the commutation logic of a brushless motor drive. A change of direction is taken only while a slow-speed qualifier is high. It then reaches the commutation decoder only after it has passed a short chain of stages that advance on the PWM-rate tick. While any stage disagrees with the stage before it, the block raises one signal that blanks every power output. The motor therefore coasts, and the high-side and low-side devices of a leg can never be commanded in overlapping directions.

Each edge of the synchronized request also gives a one-cycle trigger request to the tachometer pulse generator. This happens whether or not the reversal is accepted.

Both asynchronous inputs pass through a synchronizer. The PWM tick is a single-cycle enable in the system clock domain. Reset is synchronous and active low. During reset, every internal stage copies the present request, so the block comes out of reset with no blanking.

Top module: `dir_reversal_ctrl`

## Requirements
- R1: After reset with `dir_req` held steady, `dir_eff` equals `dir_req`, `drive_inhibit` is 0 and `tach_req` is 0.
- R2: A change on `dir_req` first shows at the outputs in the cycle after SYNC_STAGES rising clock edges have sampled it. `slow_req` is synchronized with the same delay.
- R3: While the synchronized `slow_req` is 1 (motor slow), the direction latch takes the synchronized request one cycle later.
- R4: While the synchronized `slow_req` is 0, the direction latch holds its value. `dir_eff` then keeps its value however many PWM ticks arrive.
- R5: Once the latch has a new value, `dir_eff` takes it on the HOLD_STAGES-th `pwm_tick` that follows, and not before. With no ticks, `dir_eff` does not move. A value the latch has already taken still reaches `dir_eff` after the speed qualifier drops.
- R6: `drive_inhibit` is 1 whenever the synchronized request differs from the latch output.
- R7: `drive_inhibit` is 1 whenever any hold stage, not only the last one, differs from the latch output. As a result, every cycle in which `dir_eff` changes is blanked.
- R8: Each rising or falling edge of the synchronized request gives exactly one cycle of `tach_req`, whether the motor is slow or fast.
- R9: `drive_inhibit` is 0 only when the request, the latch and every hold stage agree. It falls in the same cycle that `dir_eff` takes the agreed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_req | input | 1 | Asynchronous direction request (1 = forward) |
| slow_req | input | 1 | Asynchronous slow-speed qualifier (1 = slow enough to reverse) |
| pwm_tick | input | 1 | One-cycle enable at the PWM oscillator rate |
| dir_eff | output | 1 | Direction given to the commutation decoder |
| drive_inhibit | output | 1 | Blanks all power outputs while stages disagree |
| tach_req | output | 1 | One-cycle tachometer trigger on each request edge |

## Verification
The bench builds the block with its defaults: SYNC_STAGES = 2 and HOLD_STAGES = 2. It computes every expected sample cycle from those two values. With two hold stages, the bench can show the difference between one tick and two ticks. It can also show a request that toggles back while a value is still partway through the chain. That case leaves a stale value in the middle stage while the last stage still matches the latch, which is exactly the window that R7 must blank.

// File: rtl/dir_reversal_ctrl.sv
module dir_reversal_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_req,
  input  logic slow_req,
  input  logic pwm_tick,
  output logic dir_eff,
  output logic drive_inhibit,
  output logic tach_req
);

  localparam int SL = SYNC_STAGES - 1;
  localparam int HL = HOLD_STAGES - 1;

  logic [SL:0] dir_sync, slow_sync;
  logic [HL:0] hold_q;
  logic        dir_s, slow_s, latch_q, dir_d;

  assign dir_s  = dir_sync[SL];
  assign slow_s = slow_sync[SL];

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dir_sync  <= {SYNC_STAGES{dir_req}};
          slow_sync <= {SYNC_STAGES{slow_req}};
        end else begin
          dir_sync  <= {dir_sync[SL-1:0], dir_req};
          slow_sync <= {slow_sync[SL-1:0], slow_req};
        end
      end
    end else begin : g_sync_single
      always_ff @(posedge clk) begin
        dir_sync  <= dir_req;
        slow_sync <= slow_req;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= dir_req;
      dir_d   <= dir_req;
    end else begin
      if (slow_s) latch_q <= dir_s;
      dir_d <= dir_s;
    end
  end

  generate
    if (HOLD_STAGES > 1) begin : g_hold_chain
      always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= {HOLD_STAGES{dir_req}};
        else if (pwm_tick) hold_q <= {hold_q[HL-1:0], latch_q};
      end
    end else begin : g_hold_single
      always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= dir_req;
        else if (pwm_tick) hold_q <= latch_q;
      end
    end
  endgenerate

  assign dir_eff       = hold_q[HL];
  assign drive_inhibit = (dir_s != latch_q) || (hold_q != {HOLD_STAGES{latch_q}});
  assign tach_req      = dir_s ^ dir_d;

  p_eff_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_eff) |-> $past(pwm_tick));

  p_latch_needs_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(slow_s));

  p_eff_change_blanked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_eff) |-> $past(drive_inhibit));

  p_clear_means_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_inhibit |-> (dir_eff == dir_s));

  p_tach_follows_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tach_req |-> (dir_s != $past(dir_s)));

endmodule

// File: tb/dir_reversal_ctrl_bench.sv
module dir_reversal_ctrl_bench;
  localparam int S = 2;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst_n, dir_req, slow_req, pwm_tick;
  logic dir_eff, drive_inhibit, tach_req;

  always #4 clk = ~clk;

  dir_reversal_ctrl #(.SYNC_STAGES(S), .HOLD_STAGES(H)) u_dir_reversal_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .slow_req(slow_req),
    .pwm_tick(pwm_tick), .dir_eff(dir_eff), .drive_inhibit(drive_inhibit),
    .tach_req(tach_req)
  );

  typedef struct {
    int    when;
    bit    eff;
    bit    inh;
    bit    tach;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int k = q.size() - 1; k >= 0; k--) begin
      if (q[k].when <= cyc) begin
        checks++;
        if (q[k].when < cyc) begin
          errors++;
          $display("FAIL %s: missed sample cycle %0d (now %0d)", q[k].tag, q[k].when, cyc);
        end else if ({dir_eff, drive_inhibit, tach_req} !== {q[k].eff, q[k].inh, q[k].tach}) begin
          errors++;
          $display("FAIL %s: cycle %0d eff/inh/tach actual %b%b%b expected %b%b%b",
                   q[k].tag, cyc, dir_eff, drive_inhibit, tach_req,
                   q[k].eff, q[k].inh, q[k].tach);
        end
        q.delete(k);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int d, bit e, bit i, bit t, string tag);
    q.push_back('{cyc + d, e, i, t, tag});
  endtask

  task automatic tick();
    pwm_tick = 1'b1;
    step(1);
    pwm_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dir_req = 1'b1; slow_req = 1'b0; pwm_tick = 1'b0;
    step(4);
    rst_n = 1'b1;
    expect_at(1, 1, 0, 0, "R1 reset state");
    expect_at(3, 1, 0, 0, "R1 steady after reset");
    step(4);

    // fast: reversal refused, tach still pulses
    dir_req = 1'b0;
    expect_at(S - 1, 1, 0, 0, "R2 not yet through synchronizer");
    expect_at(S, 1, 1, 1, "R8 tach on edge while fast / R6");
    expect_at(S + 1, 1, 1, 0, "R8 single cycle / R6 latch mismatch");
    step(S + 1);
    for (int n = 0; n < 3; n++) begin
      tick();
      expect_at(0, 1, 1, 0, "R4 latch held while fast");
    end
    step(2);

    dir_req = 1'b1;
    expect_at(S, 1, 0, 1, "R8 tach on return edge / R6 cleared");
    step(S + 1);
    tick();
    expect_at(0, 1, 0, 0, "R9 all agree");
    step(2);

    // slow: accepted reversal through the hold chain
    slow_req = 1'b1; dir_req = 1'b0;
    expect_at(S, 1, 1, 1, "R6 request ahead of latch");
    expect_at(S + 1, 1, 1, 0, "R3 latch taken / R7 hold mismatch");
    step(S + 5);
    expect_at(0, 1, 1, 0, "R5 no tick no change");
    tick();
    expect_at(0, 1, 1, 0, "R5 one tick not enough");
    step(3);
    tick();
    expect_at(0, 0, 0, 0, "R5 second tick moves dir_eff / R9");
    step(2);

    // toggle back while the chain is partway
    dir_req = 1'b1;
    step(S + 2);
    tick();
    expect_at(0, 0, 1, 0, "R7 first stage ahead");
    dir_req = 1'b0;
    step(S + 2);
    expect_at(0, 0, 1, 0, "R7 stale middle stage blanks");
    tick();
    expect_at(0, 1, 1, 0, "R7 transient dir_eff blanked");
    tick();
    expect_at(0, 0, 0, 0, "R9 chain settled");
    step(2);

    // value taken while slow still completes after speed rises
    dir_req = 1'b1;
    step(S + 2);
    slow_req = 1'b0;
    step(S + 2);
    tick();
    tick();
    expect_at(0, 1, 0, 0, "R5 shift completes after speed rises");
    step(4);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9 scoreboard: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule